// File: doc/BRIEF.md
# Power Control and Wake-up Unit

This unit owns the byte-wide power control register of a small microcontroller core. It also owns a one-bit low-power memory setting. Software reaches both through a simple register port. In the same cycle that writes the register, the unit:
- works out which reset source, if any, is active;
- loads the matching reset image;
- keeps the brownout and power-on flags;
- sends brownout and watchdog events either to a reset or to an interrupt.

Software enters a low-power state by writing the sleep bits. The unit then drops the CPU clock enable alone (idle), or both the CPU and the peripheral clock enables (power-down). Wake-up events come in from the external interrupt pins, the keyboard logic, the comparators, the A/D converter, the brownout detector and the watchdog. Each one is checked against its own enable conditions. A qualified event clears the sleep bits and brings the clocks back at the next edge. The analog detectors, the watchdog counter, the converter and the CPU are outside this unit and appear only as strobes and level configuration inputs.

Top module: `pwr_ctl_unit`

## Requirements
- R1: With `reg_addr_i` = 0, a write loads all eight bits of the power control register, and `reg_rdata_o` returns the register combinationally. The bit order from 7 down to 0 is: baud doubling, framing-error select, brownout flag, power-on flag, general bit 1, general bit 0, power-down (bit 1), idle (bit 0).
- R2: While `por_i` is high, the register loads 0x30, the low-power memory bit clears and `rst_o` is high one cycle later. `por_i` wins over any other reset source present in the same cycle.
- R3: A brownout reset loads 0x20. A watchdog or external reset loads 0x00. A brownout reset in the same cycle as another non-power-on reset still gives 0x20.
- R4: When `bo_off_i` = 1, a brownout event gives no reset, no `bo_int_o` and no change to the register.
- R5: With brownout enabled, `bo_irq_mode_i` selects the result of a brownout event. When it is 0, the event is a reset and `rst_o` is high one cycle later. When it is 1, `bo_int_o` is high in the same cycle and the brownout flag (bit 5) is set at the next edge. In that case the event wakes the device only if `bo_ie_i` = 1.
- R6: When `wdt_rst_mode_i` = 1, a watchdog timeout is a reset. When it is 0, the timeout raises `wdt_int_o` and wakes the device only if `wdt_ie_i` = 1.
- R7: `ext_rst_i` causes a reset only when `ext_rst_en_i` = 1.
- R8: With `reg_addr_i` = 1, a write with bit 4 = 1 sets the low-power memory bit, which reads back at bit 4. Writing 0 there has no effect, and resets other than power-on leave the bit unchanged.
- R9: Writing the power-down bit drops both `cpu_clk_en_o` and `per_clk_en_o` from the next cycle. Writing only the idle bit drops `cpu_clk_en_o` alone.
- R10: A qualified wake-up event clears the power-down and idle bits at the next edge, restores both clock enables, and pulses `wake_o` for one cycle after that edge.
- R11: Each external interrupt, the keyboard event and each comparator wakes the device only when its own enable input is 1.
- R12: An A/D completion wakes the device only with the converter enabled and its interrupt enabled. While in power-down it also needs `adc_rcclk_i` = 1; from idle it does not.
- R13: When a software write and a hardware event fall in the same cycle, the wake clear of the sleep bits and the brownout flag set take precedence over the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = power control register, 1 = low-power memory register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| bo_evt_i | input | 1 | Brownout detector strobe |
| bo_off_i | input | 1 | Brownout detection disabled |
| bo_irq_mode_i | input | 1 | Brownout as interrupt (1) or reset (0) |
| bo_ie_i | input | 1 | Brownout interrupt enable |
| wdt_evt_i | input | 1 | Watchdog timeout strobe |
| wdt_rst_mode_i | input | 1 | Watchdog timeout resets (1) or interrupts (0) |
| wdt_ie_i | input | 1 | Watchdog interrupt enable |
| ext_rst_i | input | 1 | External reset request |
| ext_rst_en_i | input | 1 | External reset input enabled |
| ext_evt_i | input | 2 | External interrupt strobes |
| ext_ie_i | input | 2 | External interrupt enables |
| kbd_evt_i | input | 1 | Keyboard event strobe |
| kbd_ie_i | input | 1 | Keyboard interrupt enable |
| cmp_evt_i | input | 2 | Comparator event strobes |
| cmp_ie_i | input | 2 | Comparator interrupt enables |
| adc_evt_i | input | 1 | A/D conversion complete strobe |
| adc_en_i | input | 1 | A/D converter enabled |
| adc_ie_i | input | 1 | A/D interrupt enable |
| adc_rcclk_i | input | 1 | A/D runs from the internal RC clock |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| rst_o | output | 1 | Core reset request, one cycle after the source |
| wake_o | output | 1 | Wake-up pulse, one cycle after the qualifying event |
| bo_int_o | output | 1 | Brownout routed to interrupt |
| wdt_int_o | output | 1 | Watchdog routed to interrupt |
| low_pwr_mem_o | output | 1 | Low-power memory setting |

## Verification
Every stored bit is visible through the register port in the cycle after it changes, and the sleep bits also show at once on the two clock enables. A wrong reset image, a lost or stray flag, or a sleep bit that fails to clear therefore shows up on the first read or enable sample after the offending edge. Routing faults show up in the same cycle on `bo_int_o` and `wdt_int_o`, and one cycle later on `rst_o`. Wake-qualification faults show up one cycle later on `wake_o` and on the restored enables.

// File: rtl/pwrc_pkg.sv
package pwrc_pkg;

    localparam int REG_W     = 8;
    localparam int LPMEM_BIT = 4;

    localparam logic [REG_W-1:0] IMG_PWRON = 8'h30;
    localparam logic [REG_W-1:0] IMG_BROWN = 8'h20;
    localparam logic [REG_W-1:0] IMG_OTHER = 8'h00;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PWRON = 2'd1,
        SRC_BROWN = 2'd2,
        SRC_OTHER = 2'd3
    } rst_src_e;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pmode_e;

    // bit order is software-visible
    typedef struct packed {
        logic baud_x2;
        logic fe_sel;
        logic brown_flag;
        logic pwron_flag;
        logic gp1;
        logic gp0;
        logic pdown;
        logic idle;
    } pctl_t;

    typedef struct packed {
        logic bo_rst;
        logic bo_int;
        logic wdt_rst;
        logic wdt_int;
        logic ext_rst;
    } route_t;

    function automatic pctl_t reset_image(rst_src_e src);
        case (src)
            SRC_PWRON: return pctl_t'(IMG_PWRON);
            SRC_BROWN: return pctl_t'(IMG_BROWN);
            default:   return pctl_t'(IMG_OTHER);
        endcase
    endfunction

    function automatic pmode_e mode_of(pctl_t r);
        if (r.pdown)     return PM_DOWN;
        else if (r.idle) return PM_IDLE;
        else             return PM_RUN;
    endfunction

endpackage

// File: rtl/pwrc_route.sv
module pwrc_route
    import pwrc_pkg::*;
(
    input  logic     clk,
    input  logic     por_i,
    input  logic     bo_evt_i,
    input  logic     bo_off_i,
    input  logic     bo_irq_mode_i,
    input  logic     wdt_evt_i,
    input  logic     wdt_rst_mode_i,
    input  logic     ext_rst_i,
    input  logic     ext_rst_en_i,
    output route_t   route_o,
    output rst_src_e src_o
);

    always_comb begin
        route_o         = '0;
        route_o.bo_rst  = bo_evt_i && !bo_off_i && !bo_irq_mode_i;
        route_o.bo_int  = bo_evt_i && !bo_off_i &&  bo_irq_mode_i;
        route_o.wdt_rst = wdt_evt_i &&  wdt_rst_mode_i;
        route_o.wdt_int = wdt_evt_i && !wdt_rst_mode_i;
        route_o.ext_rst = ext_rst_i && ext_rst_en_i;
    end

    // priority: power-on, then brownout, then the rest
    always_comb begin
        if (por_i)
            src_o = SRC_PWRON;
        else if (route_o.bo_rst)
            src_o = SRC_BROWN;
        else if (route_o.wdt_rst || route_o.ext_rst)
            src_o = SRC_OTHER;
        else
            src_o = SRC_NONE;
    end

    AST_BO_OFF_QUIET: assert property (@(posedge clk) disable iff (por_i)
        bo_off_i |-> (!route_o.bo_rst && !route_o.bo_int)); // R4

    AST_WDT_ONE_ROUTE: assert property (@(posedge clk) disable iff (por_i)
        !(route_o.wdt_rst && route_o.wdt_int)); // R6

    AST_EXT_GATED: assert property (@(posedge clk) disable iff (por_i)
        (!ext_rst_en_i && !bo_evt_i && !wdt_evt_i) |-> (src_o == SRC_NONE)); // R7

endmodule

// File: rtl/pwrc_wake.sv
module pwrc_wake #(
    parameter int N_EXT = 2,
    parameter int N_CMP = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             in_pdown_i,
    input  logic [N_EXT-1:0] ext_evt_i,
    input  logic [N_EXT-1:0] ext_ie_i,
    input  logic             kbd_evt_i,
    input  logic             kbd_ie_i,
    input  logic [N_CMP-1:0] cmp_evt_i,
    input  logic [N_CMP-1:0] cmp_ie_i,
    input  logic             adc_evt_i,
    input  logic             adc_en_i,
    input  logic             adc_ie_i,
    input  logic             adc_rcclk_i,
    input  logic             bo_int_i,
    input  logic             bo_ie_i,
    input  logic             wdt_int_i,
    input  logic             wdt_ie_i,
    output logic             wake_o
);

    logic [N_EXT-1:0] ext_q;
    logic [N_CMP-1:0] cmp_q;
    logic             adc_q;
    logic             misc_q;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_q[g] = ext_evt_i[g] && ext_ie_i[g];
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign cmp_q[g] = cmp_evt_i[g] && cmp_ie_i[g];
    end

    // power-down stops the main clock, so the converter needs its own
    assign adc_q  = adc_evt_i && adc_en_i && adc_ie_i && (adc_rcclk_i || !in_pdown_i);
    assign misc_q = (kbd_evt_i && kbd_ie_i) || (bo_int_i && bo_ie_i) || (wdt_int_i && wdt_ie_i);

    assign wake_o = (|ext_q) || (|cmp_q) || adc_q || misc_q;

    AST_NO_WAKE_UNARMED: assert property (@(posedge clk) disable iff (por_i)
        (ext_ie_i == '0 && cmp_ie_i == '0 && !kbd_ie_i && !adc_ie_i && !bo_ie_i && !wdt_ie_i)
        |-> !wake_o); // R11

    AST_ADC_PDOWN_CLK: assert property (@(posedge clk) disable iff (por_i)
        (in_pdown_i && !adc_rcclk_i && ext_evt_i == '0 && cmp_evt_i == '0
         && !kbd_evt_i && !bo_int_i && !wdt_int_i) |-> !wake_o); // R12

endmodule

// File: rtl/pwrc_regs.sv
module pwrc_regs
    import pwrc_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  rst_src_e         src_i,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             bof_set_i,
    input  logic             wake_i,
    output pctl_t            pctl_o,
    output logic             lpmem_o
);

    pctl_t pctl_q;
    pctl_t pctl_d;
    logic  lpmem_q;

    // software first, then hardware overrides, then reset image
    always_comb begin
        pctl_d = pctl_q;
        if (wr_i && !addr_i)
            pctl_d = pctl_t'(wdata_i);
        if (bof_set_i)
            pctl_d.brown_flag = 1'b1;
        if (wake_i) begin
            pctl_d.pdown = 1'b0;
            pctl_d.idle  = 1'b0;
        end
        if (src_i != SRC_NONE)
            pctl_d = reset_image(src_i);
    end

    always_ff @(posedge clk) begin
        pctl_q <= pctl_d;
    end

    always_ff @(posedge clk) begin
        if (por_i)
            lpmem_q <= 1'b0;
        else if (wr_i && addr_i && wdata_i[LPMEM_BIT])
            lpmem_q <= 1'b1;
    end

    assign pctl_o  = pctl_q;
    assign lpmem_o = lpmem_q;

    AST_BROWN_IMAGE: assert property (@(posedge clk) disable iff (por_i)
        (src_i == SRC_BROWN) |=> (pctl_q == pctl_t'(IMG_BROWN))); // R3

    AST_OTHER_IMAGE: assert property (@(posedge clk) disable iff (por_i)
        (src_i == SRC_OTHER) |=> (pctl_q == pctl_t'(IMG_OTHER))); // R3

    AST_LPMEM_STICKY: assert property (@(posedge clk) disable iff (por_i)
        lpmem_q |=> lpmem_q); // R8

    AST_WAKE_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (por_i)
        (wake_i && src_i == SRC_NONE) |=> (!pctl_q.pdown && !pctl_q.idle)); // R10

    AST_BOF_SET: assert property (@(posedge clk) disable iff (por_i)
        (bof_set_i && src_i == SRC_NONE) |=> pctl_q.brown_flag); // R5

endmodule

// File: rtl/pwr_ctl_unit.sv
module pwr_ctl_unit
    import pwrc_pkg::*;
#(
    parameter int N_EXT = 2,
    parameter int N_CMP = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             bo_evt_i,
    input  logic             bo_off_i,
    input  logic             bo_irq_mode_i,
    input  logic             bo_ie_i,
    input  logic             wdt_evt_i,
    input  logic             wdt_rst_mode_i,
    input  logic             wdt_ie_i,
    input  logic             ext_rst_i,
    input  logic             ext_rst_en_i,
    input  logic [N_EXT-1:0] ext_evt_i,
    input  logic [N_EXT-1:0] ext_ie_i,
    input  logic             kbd_evt_i,
    input  logic             kbd_ie_i,
    input  logic [N_CMP-1:0] cmp_evt_i,
    input  logic [N_CMP-1:0] cmp_ie_i,
    input  logic             adc_evt_i,
    input  logic             adc_en_i,
    input  logic             adc_ie_i,
    input  logic             adc_rcclk_i,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             rst_o,
    output logic             wake_o,
    output logic             bo_int_o,
    output logic             wdt_int_o,
    output logic             low_pwr_mem_o
);

    route_t   route;
    rst_src_e src;
    pctl_t    pctl;
    pmode_e   mode;
    logic     wake_any;
    logic     lpmem;
    logic     rst_q;
    logic     wake_q;

    pwrc_route u_route (
        .clk            (clk),
        .por_i          (por_i),
        .bo_evt_i       (bo_evt_i),
        .bo_off_i       (bo_off_i),
        .bo_irq_mode_i  (bo_irq_mode_i),
        .wdt_evt_i      (wdt_evt_i),
        .wdt_rst_mode_i (wdt_rst_mode_i),
        .ext_rst_i      (ext_rst_i),
        .ext_rst_en_i   (ext_rst_en_i),
        .route_o        (route),
        .src_o          (src)
    );

    pwrc_wake #(
        .N_EXT (N_EXT),
        .N_CMP (N_CMP)
    ) u_wake (
        .clk         (clk),
        .por_i       (por_i),
        .in_pdown_i  (pctl.pdown),
        .ext_evt_i   (ext_evt_i),
        .ext_ie_i    (ext_ie_i),
        .kbd_evt_i   (kbd_evt_i),
        .kbd_ie_i    (kbd_ie_i),
        .cmp_evt_i   (cmp_evt_i),
        .cmp_ie_i    (cmp_ie_i),
        .adc_evt_i   (adc_evt_i),
        .adc_en_i    (adc_en_i),
        .adc_ie_i    (adc_ie_i),
        .adc_rcclk_i (adc_rcclk_i),
        .bo_int_i    (route.bo_int),
        .bo_ie_i     (bo_ie_i),
        .wdt_int_i   (route.wdt_int),
        .wdt_ie_i    (wdt_ie_i),
        .wake_o      (wake_any)
    );

    pwrc_regs u_regs (
        .clk       (clk),
        .por_i     (por_i),
        .src_i     (src),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .bof_set_i (route.bo_int),
        .wake_i    (wake_any),
        .pctl_o    (pctl),
        .lpmem_o   (lpmem)
    );

    always_ff @(posedge clk) begin
        rst_q  <= (src != SRC_NONE);
        wake_q <= por_i ? 1'b0 : wake_any;
    end

    assign mode          = mode_of(pctl);
    assign cpu_clk_en_o  = (mode == PM_RUN);
    assign per_clk_en_o  = (mode != PM_DOWN);
    assign rst_o         = rst_q;
    assign wake_o        = wake_q;
    assign bo_int_o      = route.bo_int;
    assign wdt_int_o     = route.wdt_int;
    assign low_pwr_mem_o = lpmem;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i)
            reg_rdata_o[LPMEM_BIT] = lpmem;
        else
            reg_rdata_o = pctl;
    end

    AST_WDT_RESET_ROUTE: assert property (@(posedge clk) disable iff (por_i)
        (wdt_evt_i && wdt_rst_mode_i) |=> rst_o); // R6

    AST_BROWN_RESET_ROUTE: assert property (@(posedge clk) disable iff (por_i)
        (bo_evt_i && !bo_off_i && !bo_irq_mode_i) |=> rst_o); // R5

    AST_PDOWN_STOPS_ALL: assert property (@(posedge clk) disable iff (por_i)
        (reg_wr_i && !reg_addr_i && reg_wdata_i[1] && src == SRC_NONE && !wake_any)
        |=> (!cpu_clk_en_o && !per_clk_en_o)); // R9

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (por_i)
        (wake_any && src == SRC_NONE) |=> (wake_o && cpu_clk_en_o && per_clk_en_o)); // R10

endmodule

// File: tb/pwr_ctl_unit_tb.sv
module pwr_ctl_unit_tb;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       reg_wr_i, reg_addr_i;
    logic [7:0] reg_wdata_i, reg_rdata_o;
    logic       bo_evt_i, bo_off_i, bo_irq_mode_i, bo_ie_i;
    logic       wdt_evt_i, wdt_rst_mode_i, wdt_ie_i;
    logic       ext_rst_i, ext_rst_en_i;
    logic [1:0] ext_evt_i, ext_ie_i, cmp_evt_i, cmp_ie_i;
    logic       kbd_evt_i, kbd_ie_i;
    logic       adc_evt_i, adc_en_i, adc_ie_i, adc_rcclk_i;
    logic       cpu_clk_en_o, per_clk_en_o, rst_o, wake_o, bo_int_o, wdt_int_o, low_pwr_mem_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwr_ctl_unit u_dut (
        .clk(clk), .por_i(por_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .bo_evt_i(bo_evt_i), .bo_off_i(bo_off_i), .bo_irq_mode_i(bo_irq_mode_i), .bo_ie_i(bo_ie_i),
        .wdt_evt_i(wdt_evt_i), .wdt_rst_mode_i(wdt_rst_mode_i), .wdt_ie_i(wdt_ie_i),
        .ext_rst_i(ext_rst_i), .ext_rst_en_i(ext_rst_en_i),
        .ext_evt_i(ext_evt_i), .ext_ie_i(ext_ie_i),
        .kbd_evt_i(kbd_evt_i), .kbd_ie_i(kbd_ie_i),
        .cmp_evt_i(cmp_evt_i), .cmp_ie_i(cmp_ie_i),
        .adc_evt_i(adc_evt_i), .adc_en_i(adc_en_i), .adc_ie_i(adc_ie_i), .adc_rcclk_i(adc_rcclk_i),
        .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
        .rst_o(rst_o), .wake_o(wake_o), .bo_int_o(bo_int_o), .wdt_int_o(wdt_int_o),
        .low_pwr_mem_o(low_pwr_mem_o)
    );

    // {wr, wdata, code, exp_reg, exp_cpu, exp_per, exp_rst, req}
    localparam int NV = 23;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 8'h02, 4'd0,  8'h02, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 power-down
        {1'b0, 8'h00, 4'd7,  8'h02, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 ext0 not enabled
        {1'b0, 8'h00, 4'd6,  8'h00, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 ext0 wake
        {1'b1, 8'h01, 4'd0,  8'h01, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 idle
        {1'b0, 8'h00, 4'd9,  8'h01, 1'b0, 1'b1, 1'b0, 4'd11}, // R11 keyboard not enabled
        {1'b0, 8'h00, 4'd8,  8'h00, 1'b1, 1'b1, 1'b0, 4'd11}, // R11 keyboard wake
        {1'b1, 8'h02, 4'd0,  8'h02, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
        {1'b0, 8'h00, 4'd11, 8'h02, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 no rc clock
        {1'b0, 8'h00, 4'd10, 8'h00, 1'b1, 1'b1, 1'b0, 4'd12}, // R12 rc clock
        {1'b1, 8'h02, 4'd0,  8'h02, 1'b0, 1'b0, 1'b0, 4'd1},
        {1'b0, 8'h00, 4'd3,  8'h22, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 flag, no wake
        {1'b0, 8'h00, 4'd2,  8'h20, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 wake
        {1'b1, 8'h02, 4'd0,  8'h02, 1'b0, 1'b0, 1'b0, 4'd1},
        {1'b0, 8'h00, 4'd12, 8'h02, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 detector off
        {1'b0, 8'h00, 4'd15, 8'h02, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 interrupt, no enable
        {1'b0, 8'h00, 4'd5,  8'h00, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 interrupt wake
        {1'b1, 8'h0C, 4'd0,  8'h0C, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
        {1'b0, 8'h00, 4'd14, 8'h0C, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 pin disabled
        {1'b0, 8'h00, 4'd13, 8'h00, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 pin reset
        {1'b1, 8'hC0, 4'd0,  8'hC0, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
        {1'b0, 8'h00, 4'd4,  8'h00, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 reset
        {1'b1, 8'h41, 4'd0,  8'h41, 1'b0, 1'b1, 1'b0, 4'd1},
        {1'b0, 8'h00, 4'd1,  8'h20, 1'b1, 1'b1, 1'b1, 4'd3}   // R3 brownout reset
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
        bo_evt_i = 0; bo_off_i = 0; bo_irq_mode_i = 0; bo_ie_i = 0;
        wdt_evt_i = 0; wdt_rst_mode_i = 0; wdt_ie_i = 0;
        ext_rst_i = 0; ext_rst_en_i = 0; ext_evt_i = 0; ext_ie_i = 0;
        kbd_evt_i = 0; kbd_ie_i = 0; cmp_evt_i = 0; cmp_ie_i = 0;
        adc_evt_i = 0; adc_en_i = 0; adc_ie_i = 0; adc_rcclk_i = 0;
    endtask

    task automatic drive_code(input logic [3:0] code);
        case (code)
            4'd1:  begin bo_evt_i = 1; end
            4'd2:  begin bo_evt_i = 1; bo_irq_mode_i = 1; bo_ie_i = 1; end
            4'd3:  begin bo_evt_i = 1; bo_irq_mode_i = 1; end
            4'd4:  begin wdt_evt_i = 1; wdt_rst_mode_i = 1; end
            4'd5:  begin wdt_evt_i = 1; wdt_ie_i = 1; end
            4'd6:  begin ext_evt_i = 2'b01; ext_ie_i = 2'b01; end
            4'd7:  begin ext_evt_i = 2'b01; ext_ie_i = 2'b10; end
            4'd8:  begin kbd_evt_i = 1; kbd_ie_i = 1; end
            4'd9:  begin kbd_evt_i = 1; end
            4'd10: begin adc_evt_i = 1; adc_en_i = 1; adc_ie_i = 1; adc_rcclk_i = 1; end
            4'd11: begin adc_evt_i = 1; adc_en_i = 1; adc_ie_i = 1; end
            4'd12: begin bo_evt_i = 1; bo_off_i = 1; bo_irq_mode_i = 1; bo_ie_i = 1; end
            4'd13: begin ext_rst_i = 1; ext_rst_en_i = 1; end
            4'd14: begin ext_rst_i = 1; end
            4'd15: begin wdt_evt_i = 1; end
            default: ;
        endcase
    endtask

    // entered just after a falling edge; returns just after the next one
    task automatic step(input logic wr, input logic adr, input logic [7:0] wd, input logic [3:0] code);
        reg_wr_i = wr; reg_addr_i = adr; reg_wdata_i = wd;
        drive_code(code);
        @(posedge clk);
        @(negedge clk);
        clear_in();
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_i = 0;
        #1;
        // R2 reset state
        chk("R2 reset image", reg_rdata_o, 8'h30);
        chk("R2 clocks run", {6'd0, cpu_clk_en_o, per_clk_en_o}, 8'h03);
        chk("R2 rst_o during reset", {7'd0, rst_o}, 8'h01);
        reg_addr_i = 1; #1;
        chk("R2 low-power bit cleared", reg_rdata_o, 8'h00);
        reg_addr_i = 0;
        @(negedge clk); #1;
        chk("R2 rst_o released", {7'd0, rst_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            step(v[27], 1'b0, v[26:19], v[18:15]);
            chk({tag, " reg"}, reg_rdata_o, v[14:7]);
            chk({tag, " clk"}, {6'd0, cpu_clk_en_o, per_clk_en_o}, {6'd0, v[6], v[5]});
            chk({tag, " rst"}, {7'd0, rst_o}, {7'd0, v[4]});
        end

        // R13 same-cycle write versus wake
        step(1, 0, 8'h02, 4'd0);
        step(1, 0, 8'h03, 4'd6);
        chk("R13 wake beats write", reg_rdata_o, 8'h00);
        step(1, 0, 8'h00, 4'd3);
        chk("R13 flag beats write", reg_rdata_o, 8'h20);

        // R10 wake pulse width
        step(1, 0, 8'h02, 4'd0);
        chk("R10 no pulse on write", {7'd0, wake_o}, 8'h00);
        step(0, 0, 8'h00, 4'd6);
        chk("R10 wake pulse", {7'd0, wake_o}, 8'h01);
        @(negedge clk); #1;
        chk("R10 pulse one cycle", {7'd0, wake_o}, 8'h00);

        // R12 idle wake without rc clock
        step(1, 0, 8'h01, 4'd0);
        step(0, 0, 8'h00, 4'd11);
        chk("R12 idle adc wake", reg_rdata_o, 8'h00);

        // R11 comparator enables are per channel
        step(1, 0, 8'h02, 4'd0);
        cmp_evt_i = 2'b10; cmp_ie_i = 2'b01;
        step(0, 0, 8'h00, 4'd0);
        chk("R11 comparator unarmed", reg_rdata_o, 8'h02);
        cmp_evt_i = 2'b10; cmp_ie_i = 2'b10;
        step(0, 0, 8'h00, 4'd0);
        chk("R11 comparator wake", reg_rdata_o, 8'h00);

        // R5 / R4 routing visible in the same cycle
        bo_evt_i = 1; bo_irq_mode_i = 1; #1;
        chk("R5 bo_int_o", {7'd0, bo_int_o}, 8'h01);
        bo_off_i = 1; #1;
        chk("R4 bo_int_o off", {7'd0, bo_int_o}, 8'h00);
        clear_in();
        wdt_evt_i = 1; #1;
        chk("R6 wdt_int_o", {7'd0, wdt_int_o}, 8'h01);
        clear_in(); #1;

        // R3 brownout beats watchdog
        step(1, 0, 8'hFF, 4'd0);
        wdt_evt_i = 1; wdt_rst_mode_i = 1;
        step(0, 0, 8'h00, 4'd1);
        chk("R3 brownout priority", reg_rdata_o, 8'h20);

        // R8 low-power memory bit
        step(1, 1, 8'h10, 4'd0);
        reg_addr_i = 1; #1;
        chk("R8 set", reg_rdata_o, 8'h10);
        reg_addr_i = 0;
        step(1, 1, 8'h00, 4'd0);
        chk("R8 zero ignored", {7'd0, low_pwr_mem_o}, 8'h01);
        step(0, 0, 8'h00, 4'd4);
        chk("R8 survives watchdog reset", {7'd0, low_pwr_mem_o}, 8'h01);

        // R2 power-on wins over brownout and clears the memory bit
        por_i = 1; bo_evt_i = 1;
        @(posedge clk); @(negedge clk);
        por_i = 0; clear_in(); #1;
        chk("R2 power-on priority", reg_rdata_o, 8'h30);
        chk("R8 cleared by power-on", {7'd0, low_pwr_mem_o}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule